// File: doc/BRIEF.md
# Vector Lane Shuffle Unit

This block reorders the elements of a vector that spans several processing lanes. Any output lane can take its element from any input lane. Each shuffle operation gets its permutation from one of two places. The first is a two-bit immediate code that selects one of four fixed patterns. The second is an index into a small, dedicated pattern store.

Patterns are written into that store through a separate configuration port. Each write passes through a two-stage registered pipeline before it reaches the storage array, so the write path stays short. The execute path does not wait for a write to drain from the pipeline. Its read logic compares the requested entry against both pipeline stages and forwards the youngest matching pattern. An execute therefore always sees the most recent write that was presented in an earlier cycle.

The permutation itself is a registered crossbar. Results appear one clock after the operation is accepted, together with a valid flag.

Top module: `lane_shuffle_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `out_data` is all zeros. Every pattern entry then holds all-zero source indices, so an execute from any entry copies input lane 0 into every lane.
- R2: `out_valid` equals the value that `exe_valid` had at the previous rising clock edge.
- R3: Lane i of a data vector occupies bits [32i+31:32i]. For a stored pattern, the 4-bit source index of output lane i occupies bits [4i+3:4i]. Output lane i receives the input lane named by that index.
- R4: With `exe_use_mem`=0, the pattern comes from `exe_imm_code`, and output lane i takes input lane s, where s is defined by the code:
  - code 0: s = 0 (broadcast).
  - code 1: s = 15-i (reverse).
  - code 2: s = i XOR 1 (swap adjacent pairs).
  - code 3: s = (i+1) mod 16 (rotate toward lane 0).
- R5: With `exe_use_mem`=1, the pattern comes from entry `exe_entry` and `exe_imm_code` has no effect. With `exe_use_mem`=0, `exe_entry` has no effect.
- R6: A write sampled with `cfg_valid`=1 is used by every execute of that entry sampled at any later edge, including the very next one. An execute sampled at the same edge as the write still uses the previous contents of the entry.
- R7: When the same entry is written on consecutive cycles, a later execute of that entry uses the newest write, whichever pipeline stage or the storage array holds it.
- R8: A write to one entry leaves every other entry unchanged.
- R9: When `exe_valid` is 0 at an edge, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Pattern write request |
| cfg_entry | input | 3 | Entry to write |
| cfg_pattern | input | 64 | Sixteen 4-bit source-lane indices |
| exe_valid | input | 1 | Shuffle operation request |
| exe_use_mem | input | 1 | 1: stored pattern, 0: immediate code |
| exe_imm_code | input | 2 | Immediate pattern code |
| exe_entry | input | 3 | Entry to read for a stored-pattern shuffle |
| exe_data | input | 512 | Sixteen 32-bit input lane elements |
| out_valid | output | 1 | Result valid |
| out_data | output | 512 | Permuted lane elements |

## Verification
The assertions assume that reset is held low for at least one edge before any check applies. They also assume that every input is driven to a known level at each edge. No handshake constrains `cfg_valid` or `exe_valid`, so both may be asserted every cycle, for the same entry or for different ones. The stimulus follows these assumptions by changing inputs only at the falling edge and leaving reset asserted for several edges. It also deliberately places writes and executes of one entry on the same cycle and on the two cycles that follow, so that both forwarding stages and the same-edge case are exercised next to long random traffic.

// File: rtl/shuf_pkg.sv
// Shared definitions for the lane shuffle unit.
// Assumes: immediate codes are exactly two bits wide.
package shuf_pkg;
    typedef enum logic [1:0] {
        IMM_BCAST = 2'd0,
        IMM_REV   = 2'd1,
        IMM_SWAP  = 2'd2,
        IMM_ROT   = 2'd3
    } imm_code_e;
endpackage

// File: rtl/shuf_imm_gen.sv
// Turns a two-bit immediate code into a full source-index pattern.
// Assumes: LANES is a power of two, so i^1 is always a legal lane index.
module shuf_imm_gen #(
    parameter int LANES = 16,
    parameter int IDXW  = $clog2(LANES)
) (
    input  logic [1:0]            code,
    output logic [LANES*IDXW-1:0] pattern
);
    import shuf_pkg::*;

    imm_code_e code_e;
    assign code_e = imm_code_e'(code);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [IDXW-1:0] REV_IDX = IDXW'(LANES - 1 - i);
        localparam logic [IDXW-1:0] SWP_IDX = IDXW'(i ^ 1);
        localparam logic [IDXW-1:0] ROT_IDX = IDXW'((i + 1) % LANES);

        // Pick the source index of this lane for the selected code.
        always_comb begin
            unique case (code_e)
                IMM_BCAST: pattern[i*IDXW +: IDXW] = '0;
                IMM_REV:   pattern[i*IDXW +: IDXW] = REV_IDX;
                IMM_SWAP:  pattern[i*IDXW +: IDXW] = SWP_IDX;
                default:   pattern[i*IDXW +: IDXW] = ROT_IDX;
            endcase
        end
    end
endmodule

// File: rtl/shuf_cfg_pipe.sv
// Pattern store with a two-stage registered write path. A write enters
// stage 1, moves to stage 2, and is then committed to the array. Reads
// forward the youngest in-flight write to the requested entry.
// Assumes: reads are combinational and see only writes sampled at
// earlier edges.
module shuf_cfg_pipe #(
    parameter int ENTRIES = 8,
    parameter int PATW    = 64,
    parameter int ENTW    = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [ENTW-1:0] wr_entry,
    input  logic [PATW-1:0] wr_pat,
    input  logic [ENTW-1:0] rd_entry,
    output logic [PATW-1:0] rd_pat
);
    logic            s1_v, s2_v;
    logic [ENTW-1:0] s1_e, s2_e;
    logic [PATW-1:0] s1_p, s2_p;
    logic [PATW-1:0] store [ENTRIES];

    // Advance writes through the two pipeline stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s1_e <= '0;
            s2_e <= '0;
            s1_p <= '0;
            s2_p <= '0;
        end else begin
            s1_v <= wr_valid;
            s1_e <= wr_entry;
            s1_p <= wr_pat;
            s2_v <= s1_v;
            s2_e <= s1_e;
            s2_p <= s1_p;
        end
    end

    // Commit the stage-2 write into the storage array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ENTRIES; k++) store[k] <= '0;
        end else if (s2_v) begin
            store[s2_e] <= s2_p;
        end
    end

    // Read with forwarding: stage 1 is newest, then stage 2, then array.
    always_comb begin
        if (s1_v && s1_e == rd_entry)      rd_pat = s1_p;
        else if (s2_v && s2_e == rd_entry) rd_pat = s2_p;
        else                               rd_pat = store[rd_entry];
    end

    // R6
    cfg_stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_v |=> s2_v);

    // R7
    cfg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_v |=> store[$past(s2_e)] == $past(s2_p));
endmodule

// File: rtl/shuf_xbar.sv
// One-cycle registered crossbar: output lane i takes the input lane named
// by the i-th index field of the pattern. The data register loads only
// on valid.
// Assumes: pattern is stable together with in_data for the accepting edge.
module shuf_xbar #(
    parameter int LANES = 16,
    parameter int EW    = 32,
    parameter int IDXW  = $clog2(LANES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*EW-1:0]   in_data,
    input  logic [LANES*IDXW-1:0] pattern,
    output logic                  out_valid,
    output logic [LANES*EW-1:0]   out_data
);
    logic [EW-1:0]       in_lane [LANES];
    logic [LANES*EW-1:0] nxt_data;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [IDXW-1:0] sel;
        assign in_lane[i] = in_data[i*EW +: EW];
        assign sel        = pattern[i*IDXW +: IDXW];
        assign nxt_data[i*EW +: EW] = in_lane[sel];
    end

    // Register the result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= nxt_data;
        end
    end

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

// File: rtl/lane_shuffle_unit.sv
// Top level of the vector lane shuffle unit. It chooses between the
// immediate pattern and the stored pattern, then drives the crossbar.
// The configuration port writes the pattern store independently of
// execution.
// Assumes: synchronous active-low reset, one clock domain.
module lane_shuffle_unit #(
    parameter int LANES   = 16,
    parameter int EW      = 32,
    parameter int ENTRIES = 8,
    localparam int IDXW   = $clog2(LANES),
    localparam int PATW   = LANES * IDXW,
    localparam int ENTW   = $clog2(ENTRIES),
    localparam int DW     = LANES * EW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_valid,
    input  logic [ENTW-1:0] cfg_entry,
    input  logic [PATW-1:0] cfg_pattern,
    input  logic            exe_valid,
    input  logic            exe_use_mem,
    input  logic [1:0]      exe_imm_code,
    input  logic [ENTW-1:0] exe_entry,
    input  logic [DW-1:0]   exe_data,
    output logic            out_valid,
    output logic [DW-1:0]   out_data
);
    logic [PATW-1:0] imm_pat, mem_pat, sel_pat;

    shuf_imm_gen #(.LANES(LANES), .IDXW(IDXW)) u_imm (
        .code    (exe_imm_code),
        .pattern (imm_pat)
    );

    shuf_cfg_pipe #(.ENTRIES(ENTRIES), .PATW(PATW), .ENTW(ENTW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (cfg_valid),
        .wr_entry (cfg_entry),
        .wr_pat   (cfg_pattern),
        .rd_entry (exe_entry),
        .rd_pat   (mem_pat)
    );

    // Choose the pattern source for this shuffle.
    assign sel_pat = exe_use_mem ? mem_pat : imm_pat;

    shuf_xbar #(.LANES(LANES), .EW(EW), .IDXW(IDXW)) u_xbar (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (exe_valid),
        .in_data   (exe_data),
        .pattern   (sel_pat),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: tb/tb_lane_shuffle_unit.sv
module tb_lane_shuffle_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 16;
    localparam int EW = 32;
    localparam int ENTRIES = 8;
    localparam int PATW = 64;
    localparam int DW = LANES * EW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 1'b0;
    logic [2:0] cfg_entry = '0;
    logic [PATW-1:0] cfg_pattern = '0;
    logic exe_valid = 1'b0;
    logic exe_use_mem = 1'b0;
    logic [1:0] exe_imm_code = '0;
    logic [2:0] exe_entry = '0;
    logic [DW-1:0] exe_data = '0;
    logic out_valid;
    logic [DW-1:0] out_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_shuffle_unit dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_entry(cfg_entry), .cfg_pattern(cfg_pattern),
        .exe_valid(exe_valid), .exe_use_mem(exe_use_mem),
        .exe_imm_code(exe_imm_code), .exe_entry(exe_entry), .exe_data(exe_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;
    logic [PATW-1:0] model_mem [ENTRIES];
    int last_wr [ENTRIES];
    logic exp_valid = 1'b0;
    logic [DW-1:0] exp_data = '0;
    string exp_tag = "R1";
    string force_tag = "";

    function automatic int imm_src(input int code, input int i);
        case (code)
            0: return 0;
            1: return LANES - 1 - i;
            2: return i ^ 1;
            default: return (i + 1) % LANES;
        endcase
    endfunction

    function automatic logic [DW-1:0] rand_data();
        logic [DW-1:0] d;
        for (int i = 0; i < LANES; i++) d[i*EW +: EW] = $urandom;
        return d;
    endfunction

    function automatic logic [PATW-1:0] rand_pat();
        return {$urandom, $urandom};
    endfunction

    task automatic check_outputs();
        total++;
        if (out_valid !== exp_valid) begin
            bad++;
            $display("FAIL R2 out_valid actual=%0b expected=%0b cycle=%0d", out_valid, exp_valid, cyc);
        end
        total++;
        if (out_data !== exp_data) begin
            bad++;
            $display("FAIL %s out_data actual=%h expected=%h cycle=%0d", exp_tag, out_data, exp_data, cyc);
        end
    endtask

    // One cycle: update the model, drive inputs at the falling edge, then compare.
    task automatic step(input bit cv, input int ce, input logic [PATW-1:0] cp,
                        input bit ev, input bit um, input int code, input int ee,
                        input logic [DW-1:0] data);
        if (ev) begin
            for (int i = 0; i < LANES; i++) begin
                int src;
                src = um ? int'(model_mem[ee][i*4 +: 4]) : imm_src(code, i);
                exp_data[i*EW +: EW] = data[src*EW +: EW];
            end
            if (force_tag != "") exp_tag = force_tag;
            else if (!um) exp_tag = "R4";
            else if (cyc - last_wr[ee] <= 2) exp_tag = "R6";
            else exp_tag = "R3";
        end else begin
            exp_tag = (force_tag != "") ? force_tag : "R9";
        end
        exp_valid = ev;
        if (cv) begin
            model_mem[ce] = cp;
            last_wr[ce] = cyc;
        end
        cfg_valid = cv;
        cfg_entry = 3'(ce);
        cfg_pattern = cp;
        exe_valid = ev;
        exe_use_mem = um;
        exe_imm_code = 2'(code);
        exe_entry = 3'(ee);
        exe_data = data;
        @(posedge clk);
        cyc++;
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        for (int k = 0; k < ENTRIES; k++) begin
            model_mem[k] = '0;
            last_wr[k] = -100;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state of the outputs
        exp_tag = "R1";
        check_outputs();
        rst_n = 1'b1;

        // R1: every entry broadcasts lane 0 after reset
        force_tag = "R1";
        for (int e = 0; e < ENTRIES; e++) step(0, 0, '0, 1, 1, 0, e, rand_data());

        // R4: each immediate code, with exe_entry random (ignored, R5)
        force_tag = "R4";
        for (int c = 0; c < 4; c++) step(0, 0, '0, 1, 0, c, $urandom % 8, rand_data());

        // R6: write entry 3, execute it on the same edge and on the three after
        force_tag = "R6";
        begin
            logic [PATW-1:0] p;
            p = rand_pat();
            step(1, 3, p, 1, 1, 0, 3, rand_data());
            step(0, 0, '0, 1, 1, 1, 3, rand_data());
            step(0, 0, '0, 1, 1, 2, 3, rand_data());
            step(0, 0, '0, 1, 1, 3, 3, rand_data());
        end

        // R7: back-to-back writes to one entry, newest wins
        force_tag = "R7";
        step(1, 5, rand_pat(), 0, 0, 0, 0, rand_data());
        step(1, 5, rand_pat(), 0, 0, 0, 0, rand_data());
        step(0, 0, '0, 1, 1, 0, 5, rand_data());
        step(0, 0, '0, 1, 1, 0, 5, rand_data());
        step(0, 0, '0, 1, 1, 0, 5, rand_data());

        // R5: stored form ignores the immediate code
        force_tag = "R5";
        for (int c = 0; c < 4; c++) step(0, 0, '0, 1, 1, c, 5, rand_data());

        // R8: write entry 6, other entries keep their contents
        force_tag = "R8";
        step(1, 6, rand_pat(), 0, 0, 0, 0, rand_data());
        repeat (2) step(0, 0, '0, 0, 0, 0, 0, rand_data());
        for (int e = 0; e < ENTRIES; e++) step(0, 0, '0, 1, 1, 0, e, rand_data());

        // R9: idle cycles hold the last result
        force_tag = "R9";
        repeat (4) step(0, 0, '0, 0, 1, 3, 2, rand_data());

        // R3: random stored patterns and mixed traffic
        force_tag = "";
        for (int e = 0; e < ENTRIES; e++) step(1, e, rand_pat(), 0, 0, 0, 0, rand_data());
        for (int n = 0; n < 3000; n++)
            step(($urandom % 3) == 0, $urandom % 8, rand_pat(),
                 ($urandom % 4) != 0, $urandom % 2, $urandom % 4, $urandom % 8, rand_data());

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule